// File: doc/BRIEF.md
# Endpoint FIFO / Host Port DMA Request Generator

This block decides when a cycle-steal DMA channel should move one byte between a USB endpoint FIFO and a byte-wide host-processor port. The host port has an output buffer, which the DMA fills for the host to read, and an input buffer, which the host writes and the DMA drains. A 4-bit source select picks one endpoint and one request rule. The rules are: packet-driven FIFO-to-host, byte-driven FIFO-to-host from endpoint 1, and host-to-FIFO. The block combines the selected endpoint's status flags with the host buffer flags and issues a one-cycle request pulse to the DMA channel.

Only one request may be outstanding. A new request can be raised only after the channel has acknowledged the previous one. A host-to-FIFO run stops by itself when the host writes a byte tagged as a command rather than data. A packet-driven run ends when the selected endpoint's packet-ready flag drops. Both kinds of end are reported by an end pulse.

Top module: `ep_host_dma_req`

## Requirements
- R1: No request is raised unless both `chan_en` and `cyc_steal` are 1.
- R2: For select codes 1..4 (packet mode, endpoint 1..4 = bit 0..3), a request is raised when the selected bit of `rx_pkt_rdy` is 1 and `hob_empty` is 1. Any other bit of `rx_pkt_rdy` has no effect.
- R3: For select code 5 (byte mode, endpoint 1), a request is raised when `rx_not_empty` is 1 and `hob_empty` is 1.
- R4: For select codes 6..9 (host-to-FIFO, endpoint 1..4), a request is raised when all four of these hold: `hib_full`=1, `hib_cmd`=0, the selected bit of `tx_pkt_rdy` is 0, and that endpoint's fill count (`tx_fill` slice `[8*i+7:8*i]` for endpoint i+1) is strictly less than `pkt_size`.
- R5: Select code 0 and codes 10..15 never raise a request.
- R6: `dma_req` is registered. It goes high for exactly one cycle, in the cycle after the clock edge at which its condition was sampled true.
- R7: After a request, no further request is raised until `dma_ack` has been 1 at a clock edge. The earliest next request follows the edge after that acknowledge edge.
- R8: In host-to-FIFO mode, a clock edge at which `hib_wr`=1 and `hib_cmd`=1 stops all requests and gives a one-cycle `xfer_end` pulse after that edge. Requests stay stopped until `chan_en` or `cyc_steal` is 0 at an edge.
- R9: In packet mode, a 1-to-0 change of the selected `rx_pkt_rdy` bit gives a one-cycle `xfer_end` pulse after the edge that samples the 0. A change on an unselected bit gives no pulse.
- R10: While `rst_n` is 0, `dma_req` and `xfer_end` are 0 and no request is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_en | input | 1 | Channel bridge enable |
| cyc_steal | input | 1 | Channel is in cycle-steal mode |
| src_sel | input | 4 | Endpoint and request rule select |
| rx_pkt_rdy | input | 4 | Receive packet-ready flags, endpoints 1..4 |
| rx_not_empty | input | 1 | Endpoint 1 receive FIFO holds data |
| tx_pkt_rdy | input | 4 | Transmit packet-ready flags, endpoints 1..4 |
| tx_fill | input | 32 | Transmit FIFO fill counts, 8 bits per endpoint |
| pkt_size | input | 8 | Programmed packet size limit |
| hob_empty | input | 1 | Host output buffer empty |
| hib_full | input | 1 | Host input buffer holds a byte |
| hib_cmd | input | 1 | Byte in host input buffer is a command |
| hib_wr | input | 1 | Host writes a byte into the input buffer this cycle |
| dma_ack | input | 1 | DMA channel has served the outstanding request |
| dma_req | output | 1 | One-cycle transfer request pulse |
| xfer_end | output | 1 | One-cycle end-of-run pulse |

## Verification
The hardest situation to reach is the automatic stop of a host-to-FIFO run. Every qualifying input has to be held true, so that only the stop latch suppresses the request. The stimulus first clears any outstanding request with an acknowledge. It then presents a command-tagged host write while all host-to-FIFO conditions are otherwise met. After that it returns the tag to data and shows that requests stay off. It then drops the enable for one edge and shows that requests come back. The packet-end pulse needs a similar setup: the selected flag has to fall while the output buffer is held full, so that no request mixes with the end pulse.

// File: rtl/ehd_pkg.sv
package ehd_pkg;
  // Request rule chosen by the source select
  typedef enum logic [1:0] {
    M_OFF  = 2'd0,
    M_PKT  = 2'd1,
    M_BYTE = 2'd2,
    M_H2F  = 2'd3
  } mode_e;
endpackage

// File: rtl/ehd_sel_decode.sv
module ehd_sel_decode
  import ehd_pkg::*;
#(
  parameter int NUM_EP = 4,
  parameter int SEL_W  = 4,
  parameter int EP_W   = 2
) (
  input  logic [SEL_W-1:0] sel,
  output mode_e            mode,
  output logic [EP_W-1:0]  ep
);
  // Code map: 1..NUM_EP packet, NUM_EP+1 byte (endpoint 1),
  // NUM_EP+2..2*NUM_EP+1 host-to-FIFO, everything else off.
  always_comb begin
    mode = M_OFF;
    ep   = '0;
    for (int i = 0; i < NUM_EP; i++) begin
      if (sel == SEL_W'(i + 1)) begin
        mode = M_PKT;
        ep   = EP_W'(i);
      end
      if (sel == SEL_W'(i + NUM_EP + 2)) begin
        mode = M_H2F;
        ep   = EP_W'(i);
      end
    end
    if (sel == SEL_W'(NUM_EP + 1)) begin
      mode = M_BYTE;
      ep   = '0;
    end
  end
endmodule

// File: rtl/ehd_cond.sv
module ehd_cond
  import ehd_pkg::*;
#(
  parameter int NUM_EP = 4,
  parameter int FILL_W = 8,
  parameter int EP_W   = 2
) (
  input  mode_e                   mode,
  input  logic [EP_W-1:0]         ep,
  input  logic [NUM_EP-1:0]       rx_pkt_rdy,
  input  logic                    rx_not_empty,
  input  logic [NUM_EP-1:0]       tx_pkt_rdy,
  input  logic [NUM_EP*FILL_W-1:0] tx_fill,
  input  logic [FILL_W-1:0]       pkt_size,
  input  logic                    hob_empty,
  input  logic                    hib_full,
  input  logic                    hib_cmd,
  output logic                    cond,
  output logic                    pkt_rdy_sel
);
  // Room for one more byte: fill strictly below the packet limit
  function automatic logic fifo_has_room(input logic [FILL_W-1:0] fill,
                                         input logic [FILL_W-1:0] lim);
    return fill < lim;
  endfunction

  logic [NUM_EP-1:0] room;
  logic [NUM_EP-1:0] h2f_ok;

  genvar g;
  generate
    for (g = 0; g < NUM_EP; g++) begin : g_ep
      assign room[g]   = fifo_has_room(tx_fill[g*FILL_W +: FILL_W], pkt_size);
      assign h2f_ok[g] = room[g] & ~tx_pkt_rdy[g];
    end
  endgenerate

  logic fifo_to_host_ok;
  logic host_to_fifo_ok;

  assign pkt_rdy_sel     = (mode == M_PKT) & rx_pkt_rdy[ep];
  assign fifo_to_host_ok = hob_empty;
  assign host_to_fifo_ok = hib_full & ~hib_cmd & h2f_ok[ep];

  always_comb begin
    unique case (mode)
      M_PKT:   cond = pkt_rdy_sel & fifo_to_host_ok;
      M_BYTE:  cond = rx_not_empty & fifo_to_host_ok;
      M_H2F:   cond = host_to_fifo_ok;
      default: cond = 1'b0;
    endcase
  end
endmodule

// File: rtl/ehd_req_ctl.sv
module ehd_req_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic cond,
  input  logic pkt_mode,
  input  logic pkt_rdy_sel,
  input  logic h2f_mode,
  input  logic hib_wr,
  input  logic hib_cmd,
  input  logic dma_ack,
  output logic dma_req,
  output logic xfer_end
);
  logic pend_q, stop_q, prev_rdy_q, req_q, end_q;

  // Named internal events
  logic req_fire, stop_set, pkt_fall;

  assign req_fire = active & cond & ~pend_q & ~stop_q;
  assign stop_set = active & h2f_mode & hib_wr & hib_cmd & ~stop_q;
  assign pkt_fall = active & pkt_mode & prev_rdy_q & ~pkt_rdy_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= 1'b0;
      stop_q     <= 1'b0;
      prev_rdy_q <= 1'b0;
      req_q      <= 1'b0;
      end_q      <= 1'b0;
    end else begin
      pend_q     <= (pend_q & ~dma_ack) | req_fire;
      stop_q     <= active & (stop_q | stop_set);
      prev_rdy_q <= active & pkt_mode & pkt_rdy_sel;
      req_q      <= req_fire;
      end_q      <= stop_set | pkt_fall;
    end
  end

  assign dma_req  = req_q;
  assign xfer_end = end_q;

  // R6
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |=> !dma_req);

  // R7
  no_req_while_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !dma_ack) |=> !dma_req);

  // R8
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_q |=> !dma_req);

  // R1
  gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (!dma_req && !stop_q));
endmodule

// File: rtl/ep_host_dma_req.sv
module ep_host_dma_req
  import ehd_pkg::*;
#(
  parameter int NUM_EP = 4,
  parameter int FILL_W = 8,
  parameter int SEL_W  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     chan_en,
  input  logic                     cyc_steal,
  input  logic [SEL_W-1:0]         src_sel,
  input  logic [NUM_EP-1:0]        rx_pkt_rdy,
  input  logic                     rx_not_empty,
  input  logic [NUM_EP-1:0]        tx_pkt_rdy,
  input  logic [NUM_EP*FILL_W-1:0] tx_fill,
  input  logic [FILL_W-1:0]        pkt_size,
  input  logic                     hob_empty,
  input  logic                     hib_full,
  input  logic                     hib_cmd,
  input  logic                     hib_wr,
  input  logic                     dma_ack,
  output logic                     dma_req,
  output logic                     xfer_end
);
  localparam int EP_W     = (NUM_EP > 1) ? $clog2(NUM_EP) : 1;
  localparam int LAST_SEL = 2 * NUM_EP + 1;

  mode_e           mode;
  logic [EP_W-1:0] ep;
  logic            cond, pkt_rdy_sel, active;

  assign active = chan_en & cyc_steal;

  ehd_sel_decode #(.NUM_EP(NUM_EP), .SEL_W(SEL_W), .EP_W(EP_W)) u_dec (
    .sel  (src_sel),
    .mode (mode),
    .ep   (ep)
  );

  ehd_cond #(.NUM_EP(NUM_EP), .FILL_W(FILL_W), .EP_W(EP_W)) u_cond (
    .mode         (mode),
    .ep           (ep),
    .rx_pkt_rdy   (rx_pkt_rdy),
    .rx_not_empty (rx_not_empty),
    .tx_pkt_rdy   (tx_pkt_rdy),
    .tx_fill      (tx_fill),
    .pkt_size     (pkt_size),
    .hob_empty    (hob_empty),
    .hib_full     (hib_full),
    .hib_cmd      (hib_cmd),
    .cond         (cond),
    .pkt_rdy_sel  (pkt_rdy_sel)
  );

  ehd_req_ctl u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .active      (active),
    .cond        (cond),
    .pkt_mode    (mode == M_PKT),
    .pkt_rdy_sel (pkt_rdy_sel),
    .h2f_mode    (mode == M_H2F),
    .hib_wr      (hib_wr),
    .hib_cmd     (hib_cmd),
    .dma_ack     (dma_ack),
    .dma_req     (dma_req),
    .xfer_end    (xfer_end)
  );

  // R5
  bad_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((src_sel == '0) || (src_sel > SEL_W'(LAST_SEL))) |=> !dma_req);

  // R10
  reset_out_chk: assert property (@(posedge clk)
    !rst_n |-> (!dma_req && !xfer_end));
endmodule

// File: tb/ep_host_dma_req_tb.sv
module ep_host_dma_req_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chan_en = 1'b0, cyc_steal = 1'b0;
  logic [3:0]  src_sel = '0;
  logic [3:0]  rx_pkt_rdy = '0, tx_pkt_rdy = '0;
  logic        rx_not_empty = 1'b0;
  logic [31:0] tx_fill = '0;
  logic [7:0]  pkt_size = '0;
  logic        hob_empty = 1'b0, hib_full = 1'b0, hib_cmd = 1'b0, hib_wr = 1'b0;
  logic        dma_ack = 1'b0;
  logic        dma_req, xfer_end;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ep_host_dma_req dut_i (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .cyc_steal(cyc_steal),
    .src_sel(src_sel), .rx_pkt_rdy(rx_pkt_rdy), .rx_not_empty(rx_not_empty),
    .tx_pkt_rdy(tx_pkt_rdy), .tx_fill(tx_fill), .pkt_size(pkt_size),
    .hob_empty(hob_empty), .hib_full(hib_full), .hib_cmd(hib_cmd),
    .hib_wr(hib_wr), .dma_ack(dma_ack), .dma_req(dma_req), .xfer_end(xfer_end)
  );

  typedef struct packed {
    logic       en;
    logic       cs;
    logic [3:0] sel;
    logic [3:0] rxp;
    logic       rxne;
    logic [3:0] txp;
    logic [7:0] fill;
    logic [7:0] size;
    logic       hobe;
    logic       hibf;
    logic       cmd;
    logic       exp;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t TBL [NV] = '{
    '{1'b1,1'b1,4'd1,4'b0001,1'b0,4'b0000,8'd0,8'd8,1'b1,1'b0,1'b0,1'b1}, // R2
    '{1'b1,1'b1,4'd1,4'b0010,1'b0,4'b0000,8'd0,8'd8,1'b1,1'b0,1'b0,1'b0}, // R2 other ep
    '{1'b1,1'b1,4'd2,4'b0010,1'b0,4'b0000,8'd0,8'd8,1'b1,1'b0,1'b0,1'b1}, // R2
    '{1'b1,1'b1,4'd4,4'b1000,1'b0,4'b0000,8'd0,8'd8,1'b0,1'b0,1'b0,1'b0}, // R2 buf full
    '{1'b1,1'b1,4'd4,4'b1000,1'b0,4'b0000,8'd0,8'd8,1'b1,1'b0,1'b0,1'b1}, // R2
    '{1'b1,1'b1,4'd5,4'b0000,1'b1,4'b0000,8'd0,8'd8,1'b1,1'b0,1'b0,1'b1}, // R3
    '{1'b1,1'b1,4'd5,4'b0000,1'b0,4'b0000,8'd0,8'd8,1'b1,1'b0,1'b0,1'b0}, // R3
    '{1'b1,1'b1,4'd5,4'b0000,1'b1,4'b0000,8'd0,8'd8,1'b0,1'b0,1'b0,1'b0}, // R3
    '{1'b1,1'b1,4'd6,4'b0000,1'b0,4'b0000,8'd3,8'd8,1'b0,1'b1,1'b0,1'b1}, // R4
    '{1'b1,1'b1,4'd6,4'b0000,1'b0,4'b0000,8'd8,8'd8,1'b0,1'b1,1'b0,1'b0}, // R4 at limit
    '{1'b1,1'b1,4'd6,4'b0000,1'b0,4'b0000,8'd7,8'd8,1'b0,1'b1,1'b0,1'b1}, // R4 one below
    '{1'b1,1'b1,4'd7,4'b0010,1'b0,4'b0010,8'd0,8'd8,1'b0,1'b1,1'b0,1'b0}, // R4 pkt rdy set
    '{1'b1,1'b1,4'd9,4'b0000,1'b0,4'b0111,8'd0,8'd8,1'b0,1'b1,1'b0,1'b1}, // R4 ep4
    '{1'b1,1'b1,4'd9,4'b0000,1'b0,4'b0000,8'd0,8'd8,1'b1,1'b0,1'b0,1'b0}, // R4 no data
    '{1'b1,1'b1,4'd0,4'b1111,1'b1,4'b0000,8'd0,8'd8,1'b1,1'b1,1'b0,1'b0}, // R5
    '{1'b1,1'b1,4'd12,4'b1111,1'b1,4'b0000,8'd0,8'd8,1'b1,1'b1,1'b0,1'b0},// R5
    '{1'b0,1'b1,4'd1,4'b1111,1'b1,4'b0000,8'd0,8'd8,1'b1,1'b1,1'b0,1'b0}, // R1
    '{1'b1,1'b0,4'd1,4'b1111,1'b1,4'b0000,8'd0,8'd8,1'b1,1'b1,1'b0,1'b0}, // R1
    '{1'b1,1'b1,4'd6,4'b0000,1'b0,4'b0000,8'd0,8'd8,1'b0,1'b1,1'b1,1'b0}  // R4 command byte
  };

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic clear_pend();
    chan_en = 1'b0;
    dma_ack = 1'b1;
    step();
    dma_ack = 1'b0;
    step();
  endtask

  task automatic apply(input vec_t v);
    chan_en = v.en; cyc_steal = v.cs; src_sel = v.sel;
    rx_pkt_rdy = v.rxp; rx_not_empty = v.rxne; tx_pkt_rdy = v.txp;
    tx_fill = {4{v.fill}}; pkt_size = v.size;
    hob_empty = v.hobe; hib_full = v.hibf; hib_cmd = v.cmd;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R10 reset state
    #(CLK_PERIOD * 2 + 1);
    check("R10 req", dma_req, 1'b0);
    check("R10 end", xfer_end, 1'b0);
    rst_n = 1'b1;
    step();
    check("R10 after release", dma_req, 1'b0);

    // Vector table: R1..R5, R6 timing
    for (int i = 0; i < NV; i++) begin
      apply(TBL[i]);
      step();
      check($sformatf("R1-5 vec %0d", i), dma_req, TBL[i].exp);
      clear_pend();
    end

    // R6 / R7: held condition, byte mode
    apply(TBL[5]);
    step();
    check("R6 rise", dma_req, 1'b1);
    step();
    check("R6 one cycle", dma_req, 1'b0);
    step();
    step();
    check("R7 no ack no req", dma_req, 1'b0);
    dma_ack = 1'b1;
    step();
    check("R7 ack edge", dma_req, 1'b0);
    dma_ack = 1'b0;
    step();
    check("R7 after ack", dma_req, 1'b1);
    clear_pend();

    // R8: command byte stops host-to-FIFO
    apply(TBL[8]);
    hib_cmd = 1'b1;
    hib_wr  = 1'b1;
    step();
    check("R8 end pulse", xfer_end, 1'b1);
    check("R8 no req on cmd", dma_req, 1'b0);
    hib_wr  = 1'b0;
    hib_cmd = 1'b0;
    step();
    check("R8 end one cycle", xfer_end, 1'b0);
    check("R8 stopped", dma_req, 1'b0);
    step();
    check("R8 still stopped", dma_req, 1'b0);
    chan_en = 1'b0;
    step();
    chan_en = 1'b1;
    step();
    check("R8 restart", dma_req, 1'b1);
    clear_pend();

    // R9: packet end on selected flag
    apply(TBL[0]);
    src_sel = 4'd3;
    rx_pkt_rdy = 4'b0100;
    hob_empty = 1'b0;
    step();
    step();
    check("R9 no early end", xfer_end, 1'b0);
    rx_pkt_rdy = 4'b0000;
    step();
    check("R9 end pulse", xfer_end, 1'b1);
    step();
    check("R9 end one cycle", xfer_end, 1'b0);
    rx_pkt_rdy = 4'b0001;
    step();
    rx_pkt_rdy = 4'b0000;
    step();
    check("R9 other ep no end", xfer_end, 1'b0);
    check("R9 no req", dma_req, 1'b0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule